// File: doc/BRIEF.md
# Flash Modify Protection Gate

This block sits between the register-write path and the strobes that start flash erase and program cycles. It decides, one request at a time, whether a page erase, a global erase, a word write or a read may reach the flash controller. Each permitted operation produces a one-cycle grant strobe, and each refused one produces a one-cycle `blocked` pulse. It holds three software-visible registers: an unlock key, a latched erase page and an erase command. It also takes a sticky secure input, a code-region boundary page and a requester tag that says whether a request comes from the CPU, the debug port or an SPI programmer.

A page erase is a two-step register sequence, run by a four-state machine. `PE_IDLE` goes to `PE_ARMED` when the page register is written. `PE_ARMED` goes to `PE_CHECK` when the command register is written, and it stays armed on a page rewrite. `PE_CHECK` goes to `PE_EXEC` when the latched command equals 0x55, and back to `PE_ARMED` otherwise. `PE_EXEC` always returns to `PE_IDLE`, and that is the cycle in which the erase is judged. Word writes, global erases and reads arrive on a separate request port and are judged in the cycle they are sampled.

Top module: `flash_mod_gate`

## Requirements
- R1: A word write, global erase or page erase is granted only when the 4-bit key register (register select 0, data bits [3:0]) holds 4'b0010; otherwise it raises `blocked`. Reads do not need the key.
- R2: The key does not clear itself after an operation. A second operation after one key write is still granted, and the key changes only on a write to register select 0.
- R3: A page erase needs a write of the page number (register select 1, bits [5:0]) followed by a write of 0x55 to the command register (register select 2). `perase_grant` and `perase_page` then appear in the second cycle after the command write is sampled. A 0x55 written without a page load since the last erase has no effect.
- R4: A command value other than 0x55 produces no erase strobe and no `blocked`. The sequence stays armed, so a later 0x55 erases the page already latched.
- R5: Page 0 is never page-erased; such a request raises `blocked` whatever the secure input is.
- R6: While `secure_i` is high, a page erase of a page at or above `code_bound` is blocked. Pages below the boundary are granted, and with secure low the boundary has no effect.
- R7: While secure, a word write to page 0 from the CPU (tag 0) or the debug port (tag 1) is blocked. An SPI write (tag 2) to page 0, or a CPU write to another page, is granted.
- R8: While secure, reads from any requester other than the CPU give no `rd_grant` and raise `blocked`. CPU reads are always granted, and with secure low debug reads are granted.
- R9: While secure, the debug port may only run a global erase. Its word writes and page erases are blocked (the page-erase requester is the tag that came with the command write).
- R10: `blocked` lasts one cycle. `viol_sticky` rises with it and holds until a write to register select 3 with data bit 0 set clears it; a new block in the same cycle as the clear wins.
- R11: A synchronous reset clears the key, page and command registers, the sequence state and `viol_sticky`, and drives every output low.
- R12: A request on the operation port (kind 0 read, 1 word write, 2 global erase, 3 no action) is sampled at a clock edge, and its grant or `blocked` is visible for the cycle that follows. Kind 3 produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register select: 0 key, 1 page, 2 command, 3 status clear |
| reg_wr_data | input | 8 | Register write data |
| reg_wr_src | input | 2 | Requester tag of the register write |
| secure_i | input | 1 | Sticky secure state |
| code_bound | input | 6 | First page of the protected code region |
| op_valid | input | 1 | Operation request valid |
| op_kind | input | 2 | Operation kind |
| op_src | input | 2 | Requester tag of the operation |
| op_page | input | 6 | Target page of a word write |
| rd_grant | output | 1 | Read permitted |
| wr_grant | output | 1 | Word write strobe |
| gerase_grant | output | 1 | Global erase strobe |
| perase_grant | output | 1 | Page erase strobe |
| perase_page | output | 6 | Page to erase, valid with the strobe |
| blocked | output | 1 | One-cycle refusal pulse |
| viol_sticky | output | 1 | Sticky refusal status |

## Verification
The assertions assume that `secure_i`, `code_bound` and the request fields are stable across the clock edge that samples them. They also assume that register writes and operation requests are never left undriven after reset, because several properties compare a grant with the `$past` value of those inputs. The bench drives every input on the falling edge and holds it until the next falling edge, so each value is settled around the rising edge. It never rewrites the page register while a command is being checked, which keeps the latched page that the bound property reads equal to the page the erase acted on.

// File: rtl/fmg_pkg.sv
package fmg_pkg;

    typedef enum logic [1:0] {
        SRC_CPU = 2'd0,
        SRC_DBG = 2'd1,
        SRC_SPI = 2'd2,
        SRC_EXT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_GERASE = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PE_IDLE  = 2'd0,
        PE_ARMED = 2'd1,
        PE_CHECK = 2'd2,
        PE_EXEC  = 2'd3
    } pe_state_e;

    localparam logic [1:0] SEL_KEY  = 2'd0;
    localparam logic [1:0] SEL_PAGE = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam logic [3:0] DEF_UNLOCK = 4'b0010;
    localparam logic [7:0] DEF_ERASE  = 8'h55;

    typedef struct packed {
        logic rd_go;
        logic wr_go;
        logic ge_go;
        logic pe_go;
        logic blk;
    } verdict_t;

endpackage

// File: rtl/fmg_regs.sv
module fmg_regs
    import fmg_pkg::*;
#(
    parameter int KEY_W  = 4,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [KEY_W-1:0]  key_q,
    output logic [PAGE_W-1:0] page_q,
    output logic [DATA_W-1:0] cmd_q,
    output logic              page_load,
    output logic              cmd_wr,
    output logic              stat_clr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            page_q <= '0;
            cmd_q  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                SEL_KEY:  key_q  <= wr_data[KEY_W-1:0];
                SEL_PAGE: page_q <= wr_data[PAGE_W-1:0];
                SEL_CMD:  cmd_q  <= wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        page_load = wr_en && (wr_addr == SEL_PAGE);
        cmd_wr    = wr_en && (wr_addr == SEL_CMD);
        stat_clr  = wr_en && (wr_addr == SEL_STAT) && wr_data[0];
    end

endmodule

// File: rtl/fmg_erase_seq.sv
module fmg_erase_seq
    import fmg_pkg::*;
#(
    parameter int          DATA_W     = 8,
    parameter logic [7:0]  ERASE_CODE = DEF_ERASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              page_load,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_q,
    input  logic [1:0]        wr_src,
    output logic              exec_o,
    output logic [1:0]        exec_src
);

    pe_state_e state_q, state_d;
    logic [1:0] src_q;
    logic       cmd_ok;

    assign cmd_ok = (cmd_q == DATA_W'(ERASE_CODE));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PE_IDLE;
            src_q   <= SRC_CPU;
        end else begin
            state_q <= state_d;
            if (state_q == PE_ARMED && cmd_wr) begin
                src_q <= wr_src;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PE_IDLE:  if (page_load) state_d = PE_ARMED;
            PE_ARMED: if (cmd_wr)    state_d = PE_CHECK;
            PE_CHECK: state_d = cmd_ok ? PE_EXEC : PE_ARMED;
            PE_EXEC:  state_d = PE_IDLE;
            default:  state_d = PE_IDLE;
        endcase
    end

    always_comb begin
        exec_o   = (state_q == PE_EXEC);
        exec_src = src_q;
    end

    // R4: a wrong command leaves the sequence armed
    p_cmd_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == PE_CHECK && !cmd_ok) |=> (state_q == PE_ARMED));

    // R3: the execute state lasts exactly one cycle
    p_exec_once_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == PE_EXEC) |=> (state_q == PE_IDLE));

    // R3: no erase without first passing the command check
    p_exec_entry_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(exec_o) |-> $past(state_q) == PE_CHECK);

endmodule

// File: rtl/fmg_judge.sv
module fmg_judge
    import fmg_pkg::*;
#(
    parameter int PAGE_W = 6
) (
    input  logic              key_ok,
    input  logic              secure,
    input  logic [PAGE_W-1:0] bound,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        op_src,
    input  logic [PAGE_W-1:0] op_page,
    input  logic              pe_exec,
    input  logic [1:0]        pe_src,
    input  logic [PAGE_W-1:0] pe_page,
    output verdict_t          verdict
);

    logic op_is_cpu, op_is_dbg, pe_is_dbg;
    logic op_blk, pe_blk, wr_ok, pe_ok, rd_ok;

    always_comb begin
        op_is_cpu = (op_src == SRC_CPU);
        op_is_dbg = (op_src == SRC_DBG);
        pe_is_dbg = (pe_src == SRC_DBG);

        rd_ok = !secure || op_is_cpu;
        wr_ok = key_ok
             && !(secure && op_is_dbg)
             && !(secure && (op_page == '0) && (op_is_cpu || op_is_dbg));
        pe_ok = key_ok
             && (pe_page != '0)
             && !(secure && (pe_page >= bound))
             && !(secure && pe_is_dbg);

        verdict = '0;
        op_blk  = 1'b0;
        if (op_valid) begin
            unique case (op_kind)
                OP_READ:   if (rd_ok)  verdict.rd_go = 1'b1; else op_blk = 1'b1;
                OP_WRITE:  if (wr_ok)  verdict.wr_go = 1'b1; else op_blk = 1'b1;
                OP_GERASE: if (key_ok) verdict.ge_go = 1'b1; else op_blk = 1'b1;
                default:   ;
            endcase
        end
        pe_blk = 1'b0;
        if (pe_exec) begin
            if (pe_ok) verdict.pe_go = 1'b1;
            else       pe_blk = 1'b1;
        end
        verdict.blk = op_blk || pe_blk;
    end

endmodule

// File: rtl/flash_mod_gate.sv
module flash_mod_gate
    import fmg_pkg::*;
#(
    parameter int              KEY_W      = 4,
    parameter int              PAGE_W     = 6,
    parameter int              DATA_W     = 8,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = DEF_UNLOCK,
    parameter logic [7:0]      ERASE_CODE = DEF_ERASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [1:0]        reg_wr_src,
    input  logic              secure_i,
    input  logic [PAGE_W-1:0] code_bound,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        op_src,
    input  logic [PAGE_W-1:0] op_page,
    output logic              rd_grant,
    output logic              wr_grant,
    output logic              gerase_grant,
    output logic              perase_grant,
    output logic [PAGE_W-1:0] perase_page,
    output logic              blocked,
    output logic              viol_sticky
);

    logic [KEY_W-1:0]  key_q;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] cmd_q;
    logic              page_load, cmd_wr, stat_clr;
    logic              pe_exec;
    logic [1:0]        pe_src;
    verdict_t          verdict;

    fmg_regs #(.KEY_W(KEY_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .key_q     (key_q),
        .page_q    (page_q),
        .cmd_q     (cmd_q),
        .page_load (page_load),
        .cmd_wr    (cmd_wr),
        .stat_clr  (stat_clr)
    );

    fmg_erase_seq #(.DATA_W(DATA_W), .ERASE_CODE(ERASE_CODE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .page_load (page_load),
        .cmd_wr    (cmd_wr),
        .cmd_q     (cmd_q),
        .wr_src    (reg_wr_src),
        .exec_o    (pe_exec),
        .exec_src  (pe_src)
    );

    fmg_judge #(.PAGE_W(PAGE_W)) u_judge (
        .key_ok   (key_q == UNLOCK_KEY),
        .secure   (secure_i),
        .bound    (code_bound),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_src   (op_src),
        .op_page  (op_page),
        .pe_exec  (pe_exec),
        .pe_src   (pe_src),
        .pe_page  (page_q),
        .verdict  (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_grant     <= 1'b0;
            wr_grant     <= 1'b0;
            gerase_grant <= 1'b0;
            perase_grant <= 1'b0;
            perase_page  <= '0;
            blocked      <= 1'b0;
            viol_sticky  <= 1'b0;
        end else begin
            rd_grant     <= verdict.rd_go;
            wr_grant     <= verdict.wr_go;
            gerase_grant <= verdict.ge_go;
            perase_grant <= verdict.pe_go;
            perase_page  <= verdict.pe_go ? page_q : '0;
            blocked      <= verdict.blk;
            viol_sticky  <= (viol_sticky && !stat_clr) || verdict.blk;
        end
    end

    // R1: every modify strobe was backed by the correct key
    p_key_gate_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_grant || gerase_grant || perase_grant) |-> ($past(key_q) == UNLOCK_KEY));

    // R5: page zero never reaches the page-erase strobe
    p_page0_r5: assert property (@(posedge clk) disable iff (rst)
        perase_grant |-> (perase_page != '0));

    // R6: secure page erases stay below the code boundary
    p_bound_r6: assert property (@(posedge clk) disable iff (rst)
        perase_grant |-> (!$past(secure_i) || ($past(page_q) < $past(code_bound))));

    // R8: secure reads go to the CPU only
    p_read_r8: assert property (@(posedge clk) disable iff (rst)
        rd_grant |-> (!$past(secure_i) || ($past(op_src) == SRC_CPU)));

    // R9: a secure debug port never gets a word write
    p_dbg_write_r9: assert property (@(posedge clk) disable iff (rst)
        wr_grant |-> !($past(secure_i) && ($past(op_src) == SRC_DBG)));

    // R10: a refusal always shows in the sticky status
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        blocked |-> viol_sticky);

    // R10: a clear without a new refusal empties the status
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_clr) && !blocked) |-> !viol_sticky);

endmodule

// File: tb/tb_flash_mod_gate.sv
module tb_flash_mod_gate;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_wr_addr = '0;
    logic [7:0] reg_wr_data = '0;
    logic [1:0] reg_wr_src = '0;
    logic       secure_i = 1'b0;
    logic [5:0] code_bound = 6'd63;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = 2'd3;
    logic [1:0] op_src = '0;
    logic [5:0] op_page = '0;
    logic       rd_grant, wr_grant, gerase_grant, perase_grant, blocked, viol_sticky;
    logic [5:0] perase_page;

    int checks = 0;
    int failures = 0;

    localparam logic [1:0] CPU = 2'd0, DBG = 2'd1, SPI = 2'd2;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, GE = 2'd2, NOP = 2'd3;

    always #2 clk = ~clk;

    flash_mod_gate dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_wr_src(reg_wr_src),
        .secure_i(secure_i), .code_bound(code_bound),
        .op_valid(op_valid), .op_kind(op_kind), .op_src(op_src), .op_page(op_page),
        .rd_grant(rd_grant), .wr_grant(wr_grant), .gerase_grant(gerase_grant),
        .perase_grant(perase_grant), .perase_page(perase_page),
        .blocked(blocked), .viol_sticky(viol_sticky)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d, input logic [1:0] s);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d; reg_wr_src = s;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic op(input logic [1:0] k, input logic [1:0] s, input logic [5:0] p);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; op_src = s; op_page = p;
        @(negedge clk);
        op_valid = 1'b0; op_kind = NOP;
    endtask

    task automatic perase(input logic [5:0] p, input logic [1:0] s);
        reg_wr(2'd1, {2'b00, p}, s);
        reg_wr(2'd2, 8'h55, s);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 grants low", {4'b0, rd_grant, wr_grant, gerase_grant, perase_grant}, 8'h0);
        chk("R11 blocked/sticky low", {6'b0, blocked, viol_sticky}, 8'h0);
    endtask

    task automatic t_key();
        op(GE, CPU, 0);
        chk("R1 no key gerase", {6'b0, gerase_grant, blocked}, 8'h1);
        reg_wr(2'd0, 8'h02, CPU);
        op(GE, CPU, 0);
        chk("R1 key gerase", {6'b0, gerase_grant, blocked}, 8'h2);
        op(WR, CPU, 6'd9);
        chk("R2 key kept write", {6'b0, wr_grant, blocked}, 8'h2);
        op(GE, CPU, 0);
        chk("R2 key kept gerase", {7'b0, gerase_grant}, 8'h1);
        reg_wr(2'd0, 8'h03, CPU);
        op(WR, CPU, 6'd9);
        chk("R1 wrong key write", {6'b0, wr_grant, blocked}, 8'h1);
        reg_wr(2'd0, 8'h02, CPU);
        op(NOP, CPU, 0);
        chk("R12 no-action kind", {3'b0, rd_grant, wr_grant, gerase_grant, perase_grant, blocked}, 8'h0);
        op(RD, DBG, 0);
        chk("R8 debug read unsecured", {7'b0, rd_grant}, 8'h1);
    endtask

    task automatic t_perase();
        perase(6'd5, CPU);
        chk("R3 erase strobe", {7'b0, perase_grant}, 8'h1);
        chk("R3 erase page", {2'b0, perase_page}, 8'd5);
        reg_wr(2'd2, 8'h55, CPU);
        @(negedge clk); @(negedge clk);
        chk("R3 command without page", {6'b0, perase_grant, blocked}, 8'h0);
    endtask

    task automatic t_cmd_ignore();
        reg_wr(2'd1, 8'd7, CPU);
        reg_wr(2'd2, 8'hAA, CPU);
        @(negedge clk); @(negedge clk);
        chk("R4 wrong command", {6'b0, perase_grant, blocked}, 8'h0);
        reg_wr(2'd2, 8'h55, CPU);
        @(negedge clk); @(negedge clk);
        chk("R4 still armed", {1'b0, perase_grant, perase_page}, {2'b01, 6'd7});
    endtask

    task automatic t_page0();
        reg_wr(2'd3, 8'h01, CPU);
        chk("R10 cleared start", {7'b0, viol_sticky}, 8'h0);
        perase(6'd0, CPU);
        chk("R5 page0 erase", {6'b0, perase_grant, blocked}, 8'h1);
        chk("R10 sticky set", {7'b0, viol_sticky}, 8'h1);
        @(negedge clk);
        chk("R10 pulse one cycle", {6'b0, blocked, viol_sticky}, 8'h1);
        reg_wr(2'd3, 8'h01, CPU);
        chk("R10 sticky cleared", {7'b0, viol_sticky}, 8'h0);
    endtask

    task automatic t_secure();
        secure_i = 1'b1; code_bound = 6'd20;
        perase(6'd19, CPU);
        chk("R6 below bound", {6'b0, perase_grant, blocked}, 8'h2);
        perase(6'd20, CPU);
        chk("R6 at bound", {6'b0, perase_grant, blocked}, 8'h1);
        op(WR, CPU, 0);
        chk("R7 cpu page0 write", {6'b0, wr_grant, blocked}, 8'h1);
        op(WR, SPI, 0);
        chk("R7 spi page0 write", {6'b0, wr_grant, blocked}, 8'h2);
        op(WR, CPU, 6'd3);
        chk("R7 cpu page3 write", {6'b0, wr_grant, blocked}, 8'h2);
        op(RD, DBG, 0);
        chk("R8 debug read", {6'b0, rd_grant, blocked}, 8'h1);
        op(RD, SPI, 0);
        chk("R8 spi read", {6'b0, rd_grant, blocked}, 8'h1);
        op(RD, CPU, 0);
        chk("R8 cpu read", {6'b0, rd_grant, blocked}, 8'h2);
        op(GE, DBG, 0);
        chk("R9 debug gerase", {6'b0, gerase_grant, blocked}, 8'h2);
        op(WR, DBG, 6'd4);
        chk("R9 debug write", {6'b0, wr_grant, blocked}, 8'h1);
        perase(6'd4, DBG);
        chk("R9 debug page erase", {6'b0, perase_grant, blocked}, 8'h1);
        secure_i = 1'b0;
        perase(6'd25, CPU);
        chk("R6 bound unused unsecured", {6'b0, perase_grant, blocked}, 8'h2);
    endtask

    task automatic t_reset_key();
        do_reset();
        op(GE, CPU, 0);
        chk("R11 key cleared by reset", {6'b0, gerase_grant, blocked}, 8'h1);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_key();
        t_perase();
        t_cmd_ignore();
        t_page0();
        t_secure();
        t_reset_key();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule